// File: doc/BRIEF.md
# Coarse-to-fine correlation search sequencer

This block drives a refining search for the offset at which a point template best matches an image. An external correlator computes, for each candidate position, the cross sum of template and image values (signed) and the image energy sum (unsigned). The sequencer chooses the candidate positions and collects the two sums for each one. It keeps the running best candidate by comparing normalized cross-correlation scores. The comparison cross-multiplies squared sums, so there is no division and no square root.

A search scans a 3x3 grid around a start centre. It then scans a further 3x3 grid around the winner of that grid, with the spacing halved each time. Positions are signed fixed point values with three fractional bits, so one LSB is 1/8 pixel. A grid spacing of `2^shift` LSBs is a plain shift. The default start shift of 3 gives a 1 pixel first grid, and four steps then refine the position to 1/8 pixel. When the last grid has been scored, a one-cycle done pulse is raised and the best position is held for the host.

Top module: `corr_search_seq`

## Requirements
- R1: After a synchronous reset, `cand_valid` and `done` are low and `best_x`/`best_y` are zero.
- R2: A `start` pulse is accepted only while no search is running. It latches the centre, the shift and the step count. The first candidate is the centre minus `sp` on both axes, where `sp = 2^shift` LSBs of 1/8 pixel. A `start` seen while a search runs has no effect on the candidates or the result.
- R3: Within one grid the nine candidates appear in row-major order: row offset -1, 0, +1 (times `sp`) in the outer loop, column offset -1, 0, +1 in the inner loop.
- R4: A candidate stays presented, with `cand_x`/`cand_y` stable, until `res_valid` is seen. `cand_valid` then drops in the next cycle. A `res_valid` pulse with no candidate outstanding is ignored.
- R5: A candidate with sums (P, E) replaces the best, whose sums are (Pb, Eb), when P*P*Eb > Pb*Pb*E. The test is exact for every 32-bit value of the sums, and the sign of P has no effect.
- R6: The first candidate of every search always becomes the best. When the two sides are equal, the earlier candidate is kept.
- R7: Each grid after the first is centred on the best position found so far, and its spacing is half that of the grid before. With shift 3 and four steps the spacings are 8, 4, 2 and 1 LSB.
- R8: The number of grids is the requested step count, clamped in three ways. A request of 0 counts as 1. The count is capped at `MAX_STEPS`. It never runs beyond the grid whose spacing is 1 LSB, that is, never more than shift + 1 grids. A shift above `FRAC` counts as `FRAC`.
- R9: `done` is high for exactly one cycle after the last result of the last grid. While the block is idle afterwards, no candidate is issued and `best_x`/`best_y` hold their value until a new search updates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted when idle) |
| cfg_cx | input | POS_W | Start centre X, signed, 3 fractional bits |
| cfg_cy | input | POS_W | Start centre Y, signed, 3 fractional bits |
| cfg_shift | input | $clog2(FRAC+1) | First grid spacing exponent in LSBs |
| cfg_steps | input | $clog2(MAX_STEPS+1) | Requested number of grids |
| cand_valid | output | 1 | A candidate position is outstanding |
| cand_x | output | POS_W | Candidate X |
| cand_y | output | POS_W | Candidate Y |
| res_valid | input | 1 | Sums for the outstanding candidate are present |
| res_pi | input | SUM_W | Signed template-image cross sum |
| res_ii | input | SUM_W | Unsigned image energy sum |
| done | output | 1 | One-cycle pulse at the end of the search |
| best_x | output | POS_W | Best position X |
| best_y | output | POS_W | Best position Y |

## Verification
The bench sweeps every start shift and every step request from 0 to 7. A design that clamps the grid count wrongly issues too few or too many candidates, and the done pulse then arrives early or late. A score surface with every candidate equal exercises the tie rule: a design using >= instead of > drifts to the last candidate instead of staying at the first one. Full-range sums near -2^31 and 2^32 expose a product truncated to 64 bits, which picks the wrong winner, and a score surface with a negated cross sum catches a design that does not square before it compares. A start or a stray result injected while the block is busy or idle shows whether the design restarts itself or records a phantom winner.

// File: rtl/corr_search_pkg.sv
package corr_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_SQUARE,
    ST_CMP
  } seq_state_t;

endpackage

// File: rtl/corr_axis_step.sv
// One axis of the grid generator: centre plus (-1, 0, +1) times 2^shift.
module corr_axis_step #(
  parameter int POS_W = 16,
  parameter int SHW   = 2
) (
  input  logic signed [POS_W-1:0] centre,
  input  logic [1:0]              sel,
  input  logic [SHW-1:0]          shift,
  output logic signed [POS_W-1:0] pos
);

  logic signed [POS_W-1:0] spacing;

  always_comb begin
    spacing = POS_W'(1) << shift;
    unique case (sel)
      2'd0:    pos = centre - spacing;
      2'd1:    pos = centre;
      default: pos = centre + spacing;
    endcase
  end

endmodule

// File: rtl/corr_square.sv
// Square of a signed sum, as an unsigned value of twice the width.
module corr_square #(
  parameter int SUM_W = 32
) (
  input  logic signed [SUM_W-1:0] val,
  output logic [2*SUM_W-1:0]      sq
);

  logic [SUM_W-1:0] mag;

  always_comb begin
    mag = val[SUM_W-1] ? SUM_W'(-val) : SUM_W'(val);
    sq  = {{SUM_W{1'b0}}, mag} * {{SUM_W{1'b0}}, mag};
  end

endmodule

// File: rtl/corr_ncc_cmp.sv
// Division-free score comparison: take when sq_c*ii_b > sq_b*ii_c.
module corr_ncc_cmp #(
  parameter int SUM_W = 32
) (
  input  logic [2*SUM_W-1:0] sq_c,
  input  logic [SUM_W-1:0]   ii_c,
  input  logic [2*SUM_W-1:0] sq_b,
  input  logic [SUM_W-1:0]   ii_b,
  input  logic               force_take,
  output logic               take
);

  localparam int PW = 3 * SUM_W;

  logic [PW-1:0] lhs;
  logic [PW-1:0] rhs;

  always_comb begin
    lhs  = PW'(sq_c) * PW'(ii_b);
    rhs  = PW'(sq_b) * PW'(ii_c);
    take = force_take | (lhs > rhs);
  end

endmodule

// File: rtl/corr_search_seq.sv
module corr_search_seq
  import corr_search_pkg::*;
#(
  parameter int POS_W     = 16,
  parameter int FRAC      = 3,
  parameter int SUM_W     = 32,
  parameter int MAX_STEPS = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic signed [POS_W-1:0]           cfg_cx,
  input  logic signed [POS_W-1:0]           cfg_cy,
  input  logic [$clog2(FRAC+1)-1:0]         cfg_shift,
  input  logic [$clog2(MAX_STEPS+1)-1:0]    cfg_steps,
  output logic                              cand_valid,
  output logic signed [POS_W-1:0]           cand_x,
  output logic signed [POS_W-1:0]           cand_y,
  input  logic                              res_valid,
  input  logic signed [SUM_W-1:0]           res_pi,
  input  logic [SUM_W-1:0]                  res_ii,
  output logic                              done,
  output logic signed [POS_W-1:0]           best_x,
  output logic signed [POS_W-1:0]           best_y
);

  localparam int SHW = $clog2(FRAC + 1);
  localparam int STW = $clog2(MAX_STEPS + 1);
  localparam int SQW = 2 * SUM_W;

  seq_state_t state;

  logic signed [POS_W-1:0] cen_x, cen_y;
  logic [SHW-1:0]          shift_q;
  logic [STW-1:0]          steps_left;
  logic [1:0]              col, row;
  logic                    first_q;

  logic signed [SUM_W-1:0] r_pi;
  logic [SUM_W-1:0]        r_ii;
  logic [SQW-1:0]          sq_c;
  logic [SQW-1:0]          best_sq;
  logic [SUM_W-1:0]        best_ii;

  logic [SHW-1:0]          shift_eff;
  logic [STW-1:0]          steps_eff;
  int                      steps_req;
  int                      steps_lim;

  logic [SQW-1:0]          sq_w;
  logic                    take;
  logic                    last_in_grid;

  // Start configuration, clamped to a legal search.
  always_comb begin
    shift_eff = (int'(cfg_shift) > FRAC) ? SHW'(FRAC) : cfg_shift;
    steps_req = (cfg_steps == '0) ? 1 : int'(cfg_steps);
    if (steps_req > MAX_STEPS) steps_req = MAX_STEPS;
    steps_lim = int'(shift_eff) + 1;
    if (steps_req > steps_lim) steps_req = steps_lim;
    steps_eff = STW'(steps_req);
  end

  // Grid position generator, one instance per axis.
  logic signed [POS_W-1:0] ax_centre [2];
  logic [1:0]              ax_sel    [2];
  logic signed [POS_W-1:0] ax_pos    [2];

  assign ax_centre[0] = cen_x;
  assign ax_centre[1] = cen_y;
  assign ax_sel[0]    = col;
  assign ax_sel[1]    = row;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    corr_axis_step #(
      .POS_W (POS_W),
      .SHW   (SHW)
    ) u_step (
      .centre (ax_centre[a]),
      .sel    (ax_sel[a]),
      .shift  (shift_q),
      .pos    (ax_pos[a])
    );
  end

  corr_square #(
    .SUM_W (SUM_W)
  ) u_square (
    .val (r_pi),
    .sq  (sq_w)
  );

  corr_ncc_cmp #(
    .SUM_W (SUM_W)
  ) u_cmp (
    .sq_c       (sq_c),
    .ii_c       (r_ii),
    .sq_b       (best_sq),
    .ii_b       (best_ii),
    .force_take (first_q),
    .take       (take)
  );

  assign last_in_grid = (col == 2'd2) && (row == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cand_valid <= 1'b0;
      cand_x     <= '0;
      cand_y     <= '0;
      done       <= 1'b0;
      best_x     <= '0;
      best_y     <= '0;
      best_sq    <= '0;
      best_ii    <= '0;
      cen_x      <= '0;
      cen_y      <= '0;
      shift_q    <= '0;
      steps_left <= '0;
      col        <= '0;
      row        <= '0;
      first_q    <= 1'b0;
      r_pi       <= '0;
      r_ii       <= '0;
      sq_c       <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cen_x      <= cfg_cx;
            cen_y      <= cfg_cy;
            shift_q    <= shift_eff;
            steps_left <= steps_eff;
            col        <= '0;
            row        <= '0;
            first_q    <= 1'b1;
            state      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          cand_x     <= ax_pos[0];
          cand_y     <= ax_pos[1];
          cand_valid <= 1'b1;
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (res_valid) begin
            cand_valid <= 1'b0;
            r_pi       <= res_pi;
            r_ii       <= res_ii;
            state      <= ST_SQUARE;
          end
        end
        ST_SQUARE: begin
          sq_c  <= sq_w;
          state <= ST_CMP;
        end
        ST_CMP: begin
          if (take) begin
            best_x  <= cand_x;
            best_y  <= cand_y;
            best_sq <= sq_c;
            best_ii <= r_ii;
          end
          first_q <= 1'b0;
          if (last_in_grid) begin
            col <= '0;
            row <= '0;
            if (steps_left == STW'(1)) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              steps_left <= steps_left - STW'(1);
              shift_q    <= shift_q - SHW'(1);
              cen_x      <= take ? cand_x : best_x;
              cen_y      <= take ? cand_y : best_y;
              state      <= ST_ISSUE;
            end
          end else begin
            if (col == 2'd2) begin
              col <= '0;
              row <= row + 2'd1;
            end else begin
              col <= col + 2'd1;
            end
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/corr_search_seq_chk.sv
module corr_search_seq_chk #(
  parameter int POS_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    cand_valid,
  input logic signed [POS_W-1:0] cand_x,
  input logic signed [POS_W-1:0] cand_y,
  input logic                    res_valid,
  input logic                    done,
  input logic signed [POS_W-1:0] best_x,
  input logic signed [POS_W-1:0] best_y
);

  logic rst_q;
  logic idle_q;
  logic idle_now;

  assign idle_now = idle_q | done;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) idle_q <= 1'b1;
    else     idle_q <= idle_now & ~start;
    if (rst_q) begin
      a_r1_reset_state: assert (!cand_valid && !done && best_x == '0 && best_y == '0)
        else $error("R1 outputs not cleared by reset");
    end
  end

  a_r4_cand_hold: assert property (@(posedge clk) disable iff (rst)
    cand_valid && !res_valid |=> cand_valid && $stable(cand_x) && $stable(cand_y));

  a_r4_drop_after_result: assert property (@(posedge clk) disable iff (rst)
    cand_valid && res_valid |=> !cand_valid);

  a_r9_idle_no_cand: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> !cand_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !cand_valid);

  a_r9_best_hold: assert property (@(posedge clk) disable iff (rst)
    idle_now && !start |=> $stable(best_x) && $stable(best_y));

endmodule

bind corr_search_seq corr_search_seq_chk #(
  .POS_W (POS_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .cand_valid (cand_valid),
  .cand_x     (cand_x),
  .cand_y     (cand_y),
  .res_valid  (res_valid),
  .done       (done),
  .best_x     (best_x),
  .best_y     (best_y)
);

// File: tb/corr_search_seq_tb_top.sv
module corr_search_seq_tb_top;

  localparam int POS_W     = 16;
  localparam int FRAC      = 3;
  localparam int SUM_W     = 32;
  localparam int MAX_STEPS = 4;
  localparam int SHW       = 2;
  localparam int STW       = 3;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    start = 1'b0;
  logic signed [POS_W-1:0] cfg_cx = '0;
  logic signed [POS_W-1:0] cfg_cy = '0;
  logic [SHW-1:0]          cfg_shift = '0;
  logic [STW-1:0]          cfg_steps = '0;
  logic                    res_valid = 1'b0;
  logic signed [SUM_W-1:0] res_pi = '0;
  logic [SUM_W-1:0]        res_ii = '0;
  logic                    cand_valid;
  logic signed [POS_W-1:0] cand_x, cand_y;
  logic                    done;
  logic signed [POS_W-1:0] best_x, best_y;

  int errors = 0;
  int checks = 0;
  int tx = 0;
  int ty = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  corr_search_seq #(
    .POS_W (POS_W), .FRAC (FRAC), .SUM_W (SUM_W), .MAX_STEPS (MAX_STEPS)
  ) dut_i (
    .clk (clk), .rst (rst), .start (start),
    .cfg_cx (cfg_cx), .cfg_cy (cfg_cy), .cfg_shift (cfg_shift), .cfg_steps (cfg_steps),
    .cand_valid (cand_valid), .cand_x (cand_x), .cand_y (cand_y),
    .res_valid (res_valid), .res_pi (res_pi), .res_ii (res_ii),
    .done (done), .best_x (best_x), .best_y (best_y)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // Correlator stand-in: sums for a candidate under several score surfaces.
  function automatic void score(input int mode, input int x, input int y,
                                output logic signed [31:0] pi, output logic [31:0] ii);
    longint d2;
    longint base;
    d2 = longint'(x - tx) * longint'(x - tx) + longint'(y - ty) * longint'(y - ty);
    case (mode)
      0: begin
        pi = 32'(longint'(2000000) - d2 * 50);
        ii = 32'(60000 + ((x + y) & 7) * 3);
      end
      1: begin
        pi = 32'sd777;
        ii = 32'd4321;
      end
      2: begin
        base = longint'(-2147483647) - 1;
        pi = 32'(base + d2 * 4096);
        ii = 32'(longint'(64'hFFFF_FF00) - d2 * 65536);
      end
      default: begin
        pi = 32'(-(longint'(2000000) - d2 * 50));
        ii = 32'd60000;
      end
    endcase
  endfunction

  task automatic run_search(input int cx, input int cy, input int shift_cfg, input int steps_cfg,
                            input int mode, input bit poke, output int fbx, output int fby);
    int shift_eff, nst, cenx, ceny, bx, by, cnt;
    bit first, got;
    logic [127:0] bsq, bii, sq, lhs, rhs;
    logic signed [31:0] pi;
    logic [31:0] ii;
    longint p;
    fbx = 0; fby = 0;
    shift_eff = (shift_cfg > FRAC) ? FRAC : shift_cfg;
    nst = (steps_cfg == 0) ? 1 : steps_cfg;
    if (nst > MAX_STEPS) nst = MAX_STEPS;
    if (nst > shift_eff + 1) nst = shift_eff + 1;
    cenx = cx; ceny = cy; bx = 0; by = 0; cnt = 0; first = 1'b1;
    bsq = '0; bii = '0;
    @(negedge clk);
    start = 1'b1; cfg_cx = 16'(cx); cfg_cy = 16'(cy);
    cfg_shift = 2'(shift_cfg); cfg_steps = 3'(steps_cfg);
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < nst; s++) begin
      for (int r = 0; r < 3; r++) begin
        for (int c = 0; c < 3; c++) begin
          int sp;
          int ex;
          int ey;
          string tag;
          sp = 1 << (shift_eff - s);
          ex = cenx + (c - 1) * sp;
          ey = ceny + (r - 1) * sp;
          got = 1'b0;
          for (int w = 0; w < 40; w++) begin
            if (cand_valid) begin got = 1'b1; break; end
            @(negedge clk);
          end
          check(got, "R8 candidate issued as expected", longint'(got), 1);
          if (!got) return;
          tag = (cnt == 0) ? "R2 first candidate" : ((s == 0) ? "R3 grid order" : "R7 refined grid");
          check(int'(cand_x) == ex, {tag, " x"}, longint'(cand_x), ex);
          check(int'(cand_y) == ey, {tag, " y"}, longint'(cand_y), ey);
          if (poke && cnt == 3) begin
            start = 1'b1; cfg_cx = 16'(cx + 100); cfg_shift = 2'd0;
            @(negedge clk);
            start = 1'b0; cfg_cx = 16'(cx);
            check(cand_valid && int'(cand_x) == ex, "R2 start ignored while busy",
                  longint'(cand_x), ex);
          end
          for (int d = 0; d < (cnt % 3); d++) begin
            @(negedge clk);
            check(cand_valid && int'(cand_x) == ex && int'(cand_y) == ey,
                  "R4 candidate held until result", longint'(cand_x), ex);
          end
          score(mode, ex, ey, pi, ii);
          res_valid = 1'b1; res_pi = pi; res_ii = ii;
          @(negedge clk);
          res_valid = 1'b0;
          p = longint'(pi);
          sq = 128'(p * p);
          lhs = sq * 128'(ii);
          rhs = bsq * 128'(ii);
          lhs = sq * bii;
          rhs = bsq * 128'(ii);
          if (first || lhs > rhs) begin
            bx = ex; by = ey; bsq = sq; bii = 128'(ii);
          end
          first = 1'b0;
          cnt++;
        end
      end
      cenx = bx; ceny = by;
    end
    got = 1'b0;
    for (int w = 0; w < 12; w++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check(got, "R9 done raised after last grid", longint'(got), 1);
    check(int'(best_x) == bx, "R5 R6 final best x", longint'(best_x), bx);
    check(int'(best_y) == by, "R5 R6 final best y", longint'(best_y), by);
    @(negedge clk);
    check(!done, "R9 done lasts one cycle", longint'(done), 0);
    repeat (4) @(negedge clk);
    check(!cand_valid && int'(best_x) == bx && int'(best_y) == by,
          "R9 idle after done with best held", longint'(best_x), bx);
    fbx = bx; fby = by;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog expired: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int bx, by;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cand_valid, "R1 cand_valid after reset", longint'(cand_valid), 0);
    check(!done, "R1 done after reset", longint'(done), 0);
    check(best_x == '0 && best_y == '0, "R1 best after reset", longint'(best_x), 0);

    // Default 1 px -> 1/8 px refinement reaches the exact peak; negated cross sum.
    tx = 5; ty = -3;
    run_search(0, 0, 3, 4, 3, 1'b0, bx, by);
    check(bx == 5 && by == -3, "R7 converges to 1/8 pixel peak x", bx, 5);
    check(by == -3, "R7 converges to 1/8 pixel peak y", by, -3);

    // Off-origin centre with start pokes mid-search.
    tx = -37; ty = 70;
    run_search(-40, 64, 3, 4, 0, 1'b1, bx, by);

    // All scores equal: first candidate of the search stays best.
    run_search(10, 10, 3, 4, 1, 1'b0, bx, by);
    check(bx == 2 && by == 2, "R6 ties keep first candidate", bx, 2);

    // Full-range sums.
    tx = -7; ty = 9;
    run_search(0, 0, 3, 4, 2, 1'b0, bx, by);

    // Stray result while idle.
    @(negedge clk);
    res_valid = 1'b1; res_pi = 32'sh7FFF_FFFF; res_ii = 32'd1;
    @(negedge clk);
    @(negedge clk);
    res_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(!cand_valid && !done, "R4 idle result ignored (no candidate)", longint'(cand_valid), 0);
    check(int'(best_x) == bx && int'(best_y) == by, "R4 idle result leaves best",
          longint'(best_x), bx);

    // Step count clamping sweep.
    for (int sh = 0; sh < 4; sh++) begin
      for (int st = 0; st < 8; st++) begin
        tx = sh * 3 - st; ty = st * 2 - 5;
        run_search(st - 2, sh, sh, st, (sh + st) % 4, 1'b0, bx, by);
      end
    end

    summary();
    $finish;
  end

endmodule